// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Helper

This unit sits next to an I2C controller and gives software a way to free a bus when a target device has lost count of the clock and keeps SDA held low. Software reads back the synchronized level of SDA from a status bit. While SDA is low, software can ask for a single SCL clock pulse. It repeats this, one pulse per request, until the stuck device finishes its byte and lets go of SDA.

The unit sees the raw SDA level and the SCL drive-low enable from the main controller. It produces the final open-drain SCL drive-low enable. While a pulse is in progress the unit owns SCL. It first releases the line for a set number of cycles, then pulls it low for a set number of cycles. Outside a pulse, the controller's enable passes straight through.

The register is one byte:
- bit 0 is the enable (read/write).
- bit 1 is the pulse request, which reads back as busy.
- bit 2 is the read-only SDA level.
- bits 7:3 read 0.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset `reg_rdata` is 0x00 and `scl_oe` equals `ctl_scl_oe`.
- R2: Bit 0 of the register is the enable and reads back the last value written; bits 7:3 always read 0.
- R3: Bit 2 reads the SDA level after a two-flop synchronizer, so a change on `sda_in` shows on the second rising clock edge after it. Writes to bit 2 are ignored. Bit 2 reads 0 while the enable is 0.
- R4: Writing a byte with bits 0 and 1 set, while the unit is enabled, idle and synchronized SDA is low, starts a pulse. In the first cycle after the write edge, `scl_oe` is 0 for HIGH_CYC cycles (default 1). It is then 1 for LOW_CYC cycles (default 1). After that it follows `ctl_scl_oe` again.
- R5: A request written while synchronized SDA is high starts no pulse, and bit 1 stays 0.
- R6: Bit 1 reads 1 for the whole pulse and clears itself when the pulse ends.
- R7: Writing 0 to bit 1 has no effect: it starts nothing and does not cut short a pulse that is running.
- R8: A request written while a pulse is running is ignored. The pulse is neither restarted nor lengthened.
- R9: Writing 0 to bit 0 ends any pulse at that write edge and clears all bits. A request written while the unit is disabled starts nothing.
- R10: Whenever bit 1 reads 0, `scl_oe` equals `ctl_scl_oe` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: {00000, sda, busy, enable} |
| sda_in | input | 1 | Raw SDA level from the pad |
| ctl_scl_oe | input | 1 | SCL drive-low enable from the main controller |
| scl_oe | output | 1 | Final SCL drive-low enable (1 pulls low, 0 releases) |

## Verification
A sequencer stuck outside idle would keep bit 1 at 1 and keep `scl_oe` cut off from the controller. Either symptom shows at the ports one cycle after the pulse should have ended. A gating fault on SDA shows as a released SCL cycle right after a request written while the SDA status bit read 1. A sequencer that restarts on a second request shows as a released cycle where the low phase should be. A broken abort leaves bit 1 or `scl_oe` out of line in the cycle right after the disabling write.

// File: rtl/rcv_pkg.sv
// Shared definitions for the bus recovery helper.
// Assumes: one byte-wide register, fields at fixed bit positions.
package rcv_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_EN  = 0;
    localparam int BIT_TOG = 1;
    localparam int BIT_SDA = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REL  = 2'd1,
        ST_HOLD = 2'd2
    } seq_st_t;
endpackage

// File: rtl/rcv_sync.sv
// Multi-stage synchronizer for the SDA pad level.
// Assumes: the input is asynchronous to clk; flops reset to the idle-high bus level.
module rcv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                // Shift the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gi] <= 1'b1;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rcv_regs.sv
// Register decode: holds the enable, qualifies pulse requests, builds read data.
// Assumes: writes are single-cycle strobes; a request counts only when already
// enabled, the write keeps the enable set, SDA is low and no pulse is running.
module rcv_regs
    import rcv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             sda_sync,
    input  logic             busy,
    output logic             start,
    output logic             kill,
    output logic [REG_W-1:0] rdata
);
    logic en_q;
    logic unused_hi_bits;

    // Hold the enable bit; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= 1'b0;
        else if (wr) en_q <= wdata[BIT_EN];
    end

    // Qualify a pulse request and detect a disabling write.
    always_comb begin
        start = wr && wdata[BIT_TOG] && wdata[BIT_EN] && en_q && !sda_sync && !busy;
        kill  = !en_q || (wr && !wdata[BIT_EN]);
    end

    // Assemble the read view; unused bits read 0.
    always_comb begin
        rdata          = '0;
        rdata[BIT_EN]  = en_q;
        rdata[BIT_TOG] = busy;
        rdata[BIT_SDA] = en_q & sda_sync;
    end

    assign unused_hi_bits = ^wdata[REG_W-1:BIT_SDA];
endmodule

// File: rtl/rcv_seq.sv
// Pulse sequencer: releases SCL for HIGH_CYC cycles, then pulls it low for
// LOW_CYC cycles, then returns SCL to the main controller.
// Assumes: start only arrives while idle; kill wins over everything else.
module rcv_seq
    import rcv_pkg::*;
#(
    parameter int HIGH_CYC = 1,
    parameter int LOW_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic kill,
    input  logic ctl_scl_oe,
    output logic busy,
    output logic scl_oe
);
    localparam int MAX_CYC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] HIGH_LD = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;

    // Step through the release and hold phases, counting cycles in each.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_REL;
                        cnt <= HIGH_LD;
                    end
                end
                ST_REL: begin
                    if (cnt == '0) begin
                        st  <= ST_HOLD;
                        cnt <= LOW_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // Choose who drives SCL: the sequencer during a pulse, the controller otherwise.
    always_comb begin
        busy = (st != ST_IDLE);
        case (st)
            ST_REL:  scl_oe = 1'b0;
            ST_HOLD: scl_oe = 1'b1;
            default: scl_oe = ctl_scl_oe;
        endcase
    end
endmodule

// File: rtl/i2c_bus_recovery.sv
// Top level of the stuck-SDA recovery helper: synchronizer, register decode
// and pulse sequencer.
// Assumes: sda_in is the raw pad level; scl_oe feeds an open-drain pad.
module i2c_bus_recovery
    import rcv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIGH_CYC    = 1,
    parameter int LOW_CYC     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_in,
    input  logic             ctl_scl_oe,
    output logic             scl_oe
);
    logic sda_sync;
    logic busy;
    logic start;
    logic kill;

    rcv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (sda_in),
        .d_sync (sda_sync)
    );

    rcv_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .sda_sync (sda_sync),
        .busy     (busy),
        .start    (start),
        .kill     (kill),
        .rdata    (reg_rdata)
    );

    rcv_seq #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kill       (kill),
        .ctl_scl_oe (ctl_scl_oe),
        .busy       (busy),
        .scl_oe     (scl_oe)
    );
endmodule

// File: rtl/i2c_bus_recovery_chk.sv
// Port-level property checker for the recovery helper, bound to every instance.
// Assumes: register field positions from rcv_pkg.
module i2c_bus_recovery_chk
    import rcv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr,
    input logic             wr_en,
    input logic             wr_tog,
    input logic [REG_W-1:0] rdata,
    input logic             ctl_scl_oe,
    input logic             scl_oe
);
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-1:BIT_SDA+1] == '0); // R2

    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[BIT_TOG] |-> (scl_oe == ctl_scl_oe)); // R10

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata[BIT_TOG]) |-> $past(wr && wr_tog && wr_en && rdata[BIT_EN] && !rdata[BIT_SDA])); // R5

    AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata[BIT_TOG]) |-> !scl_oe); // R4

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_en) |=> (rdata == '0)); // R9

    AST_SDA_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[BIT_EN] |-> (!rdata[BIT_SDA] && !rdata[BIT_TOG])); // R3
endmodule

bind i2c_bus_recovery i2c_bus_recovery_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wr_en      (reg_wdata[0]),
    .wr_tog     (reg_wdata[1]),
    .rdata      (reg_rdata),
    .ctl_scl_oe (ctl_scl_oe),
    .scl_oe     (scl_oe)
);

// File: tb/i2c_bus_recovery_tb.sv
`timescale 1ns/1ps
module i2c_bus_recovery_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sda_in = 1'b1;
    logic       ctl_scl_oe = 1'b0;
    logic       scl_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_bus_recovery u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sda_in     (sda_in),
        .ctl_scl_oe (ctl_scl_oe),
        .scl_oe     (scl_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr_byte(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic set_sda(input logic v);
        sda_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        ctl_scl_oe = 1'b1;
        @(negedge clk);
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 scl_oe", {7'd0, scl_oe}, 8'h01);
        ctl_scl_oe = 1'b0;
        @(negedge clk);
        check("R1 scl_oe follow", {7'd0, scl_oe}, 8'h00);
    endtask

    task automatic t_enable;
        set_sda(1'b0);
        wr_byte(8'hF9);
        check("R2 enable read, upper zero", reg_rdata, 8'h01);
        wr_byte(8'h00);
        check("R2 enable cleared", reg_rdata, 8'h00);
    endtask

    task automatic t_sda_status;
        wr_byte(8'h01);
        sda_in = 1'b1;
        @(negedge clk);
        check("R3 one edge old level", reg_rdata, 8'h01);
        @(negedge clk);
        check("R3 two edges new level", reg_rdata, 8'h05);
        wr_byte(8'h01);
        check("R3 write to sda bit ignored", reg_rdata, 8'h05);
        wr_byte(8'h00);
        check("R3 sda bit 0 when disabled", reg_rdata, 8'h00);
        wr_byte(8'h05);
        sda_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 low level", reg_rdata, 8'h01);
    endtask

    task automatic t_pulse;
        ctl_scl_oe = 1'b1;
        wr_byte(8'h03);
        check("R4 released first", {7'd0, scl_oe}, 8'h00);
        check("R6 busy during release", reg_rdata, 8'h03);
        @(negedge clk);
        check("R4 driven low after", {7'd0, scl_oe}, 8'h01);
        check("R6 busy during hold", reg_rdata, 8'h03);
        ctl_scl_oe = 1'b0;
        @(negedge clk);
        check("R6 self clear", reg_rdata, 8'h01);
        check("R10 back to controller", {7'd0, scl_oe}, 8'h00);
    endtask

    task automatic t_sda_high;
        ctl_scl_oe = 1'b1;
        set_sda(1'b1);
        wr_byte(8'h03);
        check("R5 no pulse rdata", reg_rdata, 8'h05);
        check("R5 no release", {7'd0, scl_oe}, 8'h01);
        @(negedge clk);
        check("R5 still idle", reg_rdata, 8'h05);
        set_sda(1'b0);
    endtask

    task automatic t_write0;
        ctl_scl_oe = 1'b1;
        wr_byte(8'h01);
        check("R7 zero starts nothing", reg_rdata, 8'h01);
        check("R7 scl follows", {7'd0, scl_oe}, 8'h01);
        ctl_scl_oe = 1'b0;
        wr_byte(8'h03);
        wr_byte(8'h01);
        check("R7 pulse continues", reg_rdata, 8'h03);
        check("R7 hold phase", {7'd0, scl_oe}, 8'h01);
        @(negedge clk);
        check("R7 ends on time", reg_rdata, 8'h01);
    endtask

    task automatic t_retrigger;
        ctl_scl_oe = 1'b0;
        wr_byte(8'h03);
        wr_byte(8'h03);
        check("R8 not restarted", {7'd0, scl_oe}, 8'h01);
        @(negedge clk);
        check("R8 not lengthened", reg_rdata, 8'h01);
        check("R8 scl back", {7'd0, scl_oe}, 8'h00);
    endtask

    task automatic t_disable;
        ctl_scl_oe = 1'b1;
        wr_byte(8'h03);
        wr_byte(8'h00);
        check("R9 abort clears", reg_rdata, 8'h00);
        check("R9 scl to controller", {7'd0, scl_oe}, 8'h01);
        wr_byte(8'h02);
        check("R9 request while disabled", reg_rdata, 8'h00);
        check("R9 no release", {7'd0, scl_oe}, 8'h01);
        @(negedge clk);
        check("R9 stays idle", reg_rdata, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_sda_status();
        t_pulse();
        t_sda_high();
        t_write0();
        t_retrigger();
        t_disable();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule